// File: doc/BRIEF.md
# Five-Stage Load/Store Pipeline Core

This block is a small in-order integer core for a register machine in which only loads and stores touch memory. Each instruction passes through five stages: fetch, decode with register read, execute, memory access and write-back. The instruction and the data memories each answer in the same cycle they are addressed, so one new instruction can enter fetch every cycle while each instruction still takes five cycles to finish.

The core has eight general registers and four operations: load from memory at a base register plus a signed displacement, store to memory at the same kind of address, register-register add, and no-op. There is no forwarding path between stages. Decode instead holds back any instruction that reads a register still being produced in execute or memory. A result in write-back reaches decode in the same cycle because the register file writes before it reads. A debug port reads any register directly.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0, `dmem_we` is 0, every register reads 0 through the debug port, and every stage is empty. No register or memory write happens until a real instruction reaches write-back or the memory stage.
- R2: An instruction is 16 bits: opcode in [15:12], destination `rd` in [11:9], source `rs` in [8:6], and a signed 6-bit displacement in [5:0]. Opcode 1 is LOAD, 2 is STORE and 3 is ADD. Opcode 0 and every other value act as a no-op that changes neither a register nor memory.
- R3: LOAD sets `rd` to the data memory word at the low AW bits of `R[rs]` plus the sign-extended displacement.
- R4: STORE drives `dmem_we` high for one cycle with `dmem_wdata` = `R[rd]` and `dmem_addr` = the low AW bits of `R[rs]` plus the sign-extended displacement. Only stores assert `dmem_we`.
- R5: ADD sets `rd` to `R[rs]` + `R[t]`, where `t` is displacement bits [2:0].
- R6: With no hazard, `imem_addr` advances by one every cycle. The result of an instruction fetched at the first clock edge after reset is in the register file after the fifth edge and is not there after the fourth.
- R7: When decode holds an instruction that reads a register which a valid LOAD or ADD in execute or memory will write, `imem_addr` and decode hold and a bubble enters execute. A reader placed directly after its producer therefore waits exactly two extra cycles.
- R8: A register written in write-back is seen by a read in decode during the same cycle, so a reader three instructions after its producer does not stall.
- R9: Only operands an operation uses can cause a hold. LOAD reads only `rs`, STORE reads `rs` and `rd`, ADD reads `rs` and `t`, and a no-op reads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | AW | Instruction memory address (the program counter) |
| imem_data | input | 16 | Instruction word returned in the same cycle |
| dmem_addr | output | AW | Data memory address |
| dmem_rdata | input | DW | Data word returned in the same cycle |
| dmem_wdata | output | DW | Store data |
| dmem_we | output | 1 | Store strobe |
| dbg_sel | input | 3 | Register selected for debug read |
| dbg_data | output | DW | Contents of the selected register |

## Verification
The assertions check on every cycle how the hold works. During a hold the fetch address freezes and the next execute slot is empty. No hold lasts more than two cycles. Without a hold the address steps by one. A store strobe always follows a store in execute, and a register write always follows a valid memory stage. Only the bench program can show the values that loads, stores and adds produce, sign extension with address wrap, the same-cycle write-back bypass, and that unused operand fields and unknown opcodes cause neither a hold nor a write. The bench measures these through how long each fetch address is held and through the final contents of the registers and the memory.

// File: rtl/pipe5_core.sv
module pipe5_core #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] imem_addr,
  input  logic [15:0]   imem_data,
  output logic [AW-1:0] dmem_addr,
  input  logic [DW-1:0] dmem_rdata,
  output logic [DW-1:0] dmem_wdata,
  output logic          dmem_we,
  input  logic [2:0]    dbg_sel,
  output logic [DW-1:0] dbg_data
);
  localparam int NREG = 8;
  localparam logic [3:0] OP_LOAD = 4'd1, OP_STORE = 4'd2, OP_ADD = 4'd3;

  logic [DW-1:0] rf [NREG];

  logic [AW-1:0] pc;
  logic [15:0]   ir;
  logic          d_valid;

  logic          ex_valid;
  logic [3:0]    ex_op;
  logic [2:0]    ex_rd;
  logic [DW-1:0] ex_a, ex_b, ex_imm;

  logic          mem_valid;
  logic [3:0]    mem_op;
  logic [2:0]    mem_rd;
  logic [DW-1:0] mem_t2, mem_b;

  logic          wb_we;
  logic [2:0]    wb_rd;
  logic [DW-1:0] wb_data;

  wire [3:0] d_op = ir[15:12];
  wire [2:0] d_rd = ir[11:9];
  wire [2:0] d_rs = ir[8:6];
  wire [2:0] d_rt = (d_op == OP_STORE) ? d_rd : ir[2:0];
  wire [DW-1:0] d_disp = {{(DW-6){ir[5]}}, ir[5:0]};
  wire d_use_a = d_valid && (d_op == OP_LOAD || d_op == OP_STORE || d_op == OP_ADD);
  wire d_use_b = d_valid && (d_op == OP_STORE || d_op == OP_ADD);

  wire [DW-1:0] rd_a = (wb_we && wb_rd == d_rs) ? wb_data : rf[d_rs];
  wire [DW-1:0] rd_b = (wb_we && wb_rd == d_rt) ? wb_data : rf[d_rt];

  wire ex_wr  = ex_valid  && (ex_op  == OP_LOAD || ex_op  == OP_ADD);
  wire mem_wr = mem_valid && (mem_op == OP_LOAD || mem_op == OP_ADD);

  wire haz_a = d_use_a && ((ex_wr && ex_rd == d_rs) || (mem_wr && mem_rd == d_rs));
  wire haz_b = d_use_b && ((ex_wr && ex_rd == d_rt) || (mem_wr && mem_rd == d_rt));
  wire stall = haz_a || haz_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      ir        <= '0;
      d_valid   <= 1'b0;
      ex_valid  <= 1'b0;
      ex_op     <= '0;
      ex_rd     <= '0;
      ex_a      <= '0;
      ex_b      <= '0;
      ex_imm    <= '0;
      mem_valid <= 1'b0;
      mem_op    <= '0;
      mem_rd    <= '0;
      mem_t2    <= '0;
      mem_b     <= '0;
      wb_we     <= 1'b0;
      wb_rd     <= '0;
      wb_data   <= '0;
    end else begin
      if (!stall) begin
        pc      <= pc + 1'b1;
        ir      <= imem_data;
        d_valid <= 1'b1;
      end
      ex_valid  <= d_valid && !stall;
      ex_op     <= d_op;
      ex_rd     <= d_rd;
      ex_a      <= rd_a;
      ex_b      <= rd_b;
      ex_imm    <= d_disp;
      mem_valid <= ex_valid;
      mem_op    <= ex_op;
      mem_rd    <= ex_rd;
      mem_t2    <= ex_a + ((ex_op == OP_ADD) ? ex_b : ex_imm);
      mem_b     <= ex_b;
      wb_we     <= mem_wr;
      wb_rd     <= mem_rd;
      wb_data   <= (mem_op == OP_LOAD) ? dmem_rdata : mem_t2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wb_we) begin
      rf[wb_rd] <= wb_data;
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = mem_t2[AW-1:0];
  assign dmem_wdata = mem_b;
  assign dmem_we    = mem_valid && (mem_op == OP_STORE);
  assign dbg_data   = rf[dbg_sel];

  AST_HOLD_FREEZES_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> imem_addr == $past(imem_addr)); // R7
  AST_HOLD_INSERTS_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !ex_valid); // R7
  AST_HOLD_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && $past(stall)) |=> !stall); // R7
  AST_FETCH_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> imem_addr == $past(imem_addr) + 1'b1); // R6
  AST_STROBE_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> $past(ex_valid && ex_op == OP_STORE)); // R4
  AST_WRITE_FROM_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> $past(mem_valid)); // R6
endmodule

// File: tb/pipe5_core_tb_top.sv
module pipe5_core_tb_top;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;

  localparam logic [15:0] PROG [12] = '{
    16'h1205, 16'h143E, 16'h1602, 16'h00C3, 16'h3642, 16'h260A,
    16'h180A, 16'h1B01, 16'h3D45, 16'h3F81, 16'h2E70, 16'hF280};
  localparam int DWELL_EXP [16] = '{1,1,1,1,1,1,3,1,3,3,3,3,1,1,1,1};
  localparam string DWELL_REQ [16] = '{"R6","R6","R6","R9","R9","R8","R7","R6",
                                       "R7","R7","R7","R7","R2","R6","R6","R6"};
  localparam int REG_EXP [8] = '{0, 16, 763, 779, 779, 37, 74, 90};
  localparam string REG_REQ [8] = '{"R1","R2","R3","R5","R3","R3","R5","R5"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [15:0]   imem_data;
  logic [AW-1:0] dmem_addr;
  logic [DW-1:0] dmem_rdata;
  logic [DW-1:0] dmem_wdata;
  logic          dmem_we;
  logic [2:0]    dbg_sel = 3'd0;
  logic [DW-1:0] dbg_data;

  logic [15:0]   imem [DEPTH];
  logic [DW-1:0] dmem [DEPTH];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int dwell [16];
  int we_cnt = 0;

  always #2 clk = ~clk;

  pipe5_core #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata),
    .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data));

  assign imem_data  = imem[imem_addr];
  assign dmem_rdata = dmem[dmem_addr];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr] <= dmem_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      imem[i] = (i < 12) ? PROG[i] : 16'h0000;
      dmem[i] = DW'(i * 3 + 1);
    end
    for (int i = 0; i < 16; i++) dwell[i] = 0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(imem_addr == 0, "R1", int'(imem_addr), 0);
    chk(dmem_we == 1'b0, "R1", int'(dmem_we), 0);
    for (int r = 0; r < 8; r++) begin
      dbg_sel = 3'(r);
      #0.5;
      chk(dbg_data == 0, "R1", int'(dbg_data), 0);
    end

    dbg_sel = 3'd1;
    rst_n = 1'b1;
    for (int k = 0; k < 60; k++) begin
      if (imem_addr < 16) dwell[imem_addr]++;
      if (dmem_we) we_cnt++;
      if (k == 4) chk(dbg_data == 0,  "R6", int'(dbg_data), 0);
      if (k == 5) chk(dbg_data == 16, "R6", int'(dbg_data), 16);
      @(negedge clk);
    end

    for (int a = 0; a < 16; a++)
      chk(dwell[a] == DWELL_EXP[a], DWELL_REQ[a], dwell[a], DWELL_EXP[a]);

    for (int r = 0; r < 8; r++) begin
      dbg_sel = 3'(r);
      #0.5;
      chk(int'(dbg_data) == REG_EXP[r], REG_REQ[r], int'(dbg_data), REG_EXP[r]);
    end

    chk(dmem[10] == 779, "R4", int'(dmem[10]), 779);
    chk(dmem[0] == 90,   "R4", int'(dmem[0]), 90);
    chk(dmem[12] == 37,  "R4", int'(dmem[12]), 37);
    chk(dmem[254] == 763, "R4", int'(dmem[254]), 763);
    chk(we_cnt == 2,     "R4", we_cnt, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule